// File: doc/BRIEF.md
# Programmable Sample Clock Generator

This block derives an audio-style sample strobe from a fixed 24.576 MHz master clock. Software sets the output rate directly in hertz through a 16-bit rate word. A modulo phase accumulator adds that word on every master clock. Each time the accumulator crosses the modulus, the block raises a one-cycle strobe, so the average strobe frequency equals the word in Hz.

A second register requests a phase shift of the strobe. It holds a direction bit and an 8-bit magnitude, with one step worth 0.12 degrees of the sample period. The generator works through the pending steps in the background, one every eight master cycles. Each step nudges the accumulator forward or backward by 8192, which is 1/3000 of the modulus. Software can read the remaining magnitude at any time, and can replace it at any time.

Reset, power-down and the generator-enable input force the registers to their defaults and make them refuse writes.

Top module: `samp_clk_gen`

## Requirements
- R1: The strobe is high for one cycle and is never high in two consecutive cycles. Over any window of 12288 cycles, the number of strobes equals floor(12288·rate/24576000) or one more.
- R2: R1 holds at the rate limits 4000 Hz (0x0FA0) and 54000 Hz (0xD2F0).
- R3: The rate register reads 0xBB80 (48000 Hz) through rd_sel=0 after reset. While rst or pwr_dn is high, it returns to that value and ignores writes. It is written with wr_en=1 and wr_sel=0.
- R4: The shift register is written with wr_en=1 and wr_sel=1, and read with rd_sel=1. Bits [7:0] hold the magnitude. Bit 8 is the direction: 0 advances the phase and 1 retards it. Bits [15:9] read as 0, and writing them has no effect.
- R5: While rst or pwr_dn is high, or gen_en is low, the shift register is cleared to 0 and ignores writes.
- R6: A magnitude N loaded at clock edge P reads N−floor(m/8) m cycles later, and reaches 0 exactly 8·N cycles after P.
- R7: A write during a pending shift replaces the remaining magnitude and direction. The eight-cycle step timing restarts from that write.
- R8: Each advance step adds 8192 to the accumulator. At rate 8192 Hz the strobe period is 3000 cycles, and an advance of N shortens one period by exactly N cycles.
- R9: Each retard step subtracts 8192. At rate 8192 Hz, a retard of N lengthens one period by exactly N cycles.
- R10: The accumulator always stays in [0, 24576000). When a retard step takes it below zero, it wraps to the top of the range with no strobe, and the next forward wrap emits no strobe. As a result no sample edge repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down, active high; forces registers to defaults |
| gen_en | input | 1 | Generator enable; low clears and locks the shift register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 rate word, 1 shift register |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 rate word, 1 shift register |
| rd_data | output | 16 | Read data of the selected register |
| strobe | output | 1 | One-cycle sample strobe |

## Verification
The bench counts strobes over fixed windows at both range limits, at the default rate and at a rate with a fractional count per window. A wrong modulus or a wrong wrap shows up there as a count that is off by more than one.

The step timing is probed at the exact cycles 8·N−1 and 8·N after a load, and again after an overwrite. A prescaler that does not restart, or that is off by one, therefore reads the wrong remaining magnitude.

At 8192 Hz, advance and retard must move one strobe period by exactly N cycles. A wrong step size or a wrong sign changes the measured interval.

The retard step is also timed to land one cycle after a wrap, so that it carries the accumulator below zero. A design without the suppression of the repeated edge emits a second strobe two cycles later. A design that mishandles the negative sum leaves the valid range.

// File: rtl/samp_clk_pkg.sv
package samp_clk_pkg;

    parameter int MCLK_HZ    = 24_576_000;
    parameter int RATE_W     = 16;
    parameter int MAG_W      = 8;
    parameter int REG_W      = 16;
    parameter int TICK_DIV   = 8;
    parameter int STEPS_PER_PERIOD = 3000;
    parameter logic [RATE_W-1:0] RATE_DEF = 16'hBB80;

    localparam int SHIFT_STEP = MCLK_HZ / STEPS_PER_PERIOD;
    localparam int ACC_W      = $clog2(MCLK_HZ + (1 << RATE_W) + SHIFT_STEP) + 1;
    localparam int DIV_W      = $clog2(TICK_DIV);
    localparam int RSV_W      = REG_W - MAG_W - 1;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_FWD  = 2'd1,
        ADJ_BACK = 2'd2
    } adj_e;

    typedef struct packed {
        logic             dir;
        logic [MAG_W-1:0] mag;
    } shift_t;

    typedef struct packed {
        logic [ACC_W-2:0] acc;
        logic             fwd;
        logic             back;
    } acc_step_t;

    function automatic acc_step_t acc_advance(input logic [ACC_W-2:0] acc,
                                              input logic [RATE_W-1:0] rate,
                                              input adj_e adj);
        logic signed [ACC_W-1:0] sum;
        logic signed [ACC_W-1:0] step;
        logic signed [ACC_W-1:0] modv;
        logic signed [ACC_W-1:0] nxt;
        acc_step_t               res;
        modv = ACC_W'(MCLK_HZ);
        case (adj)
            ADJ_FWD:  step = ACC_W'(SHIFT_STEP);
            ADJ_BACK: step = -ACC_W'(SHIFT_STEP);
            default:  step = '0;
        endcase
        sum = $signed({1'b0, acc}) + $signed({{(ACC_W-RATE_W){1'b0}}, rate}) + step;
        res.fwd  = 1'b0;
        res.back = 1'b0;
        if (sum >= modv) begin
            nxt     = sum - modv;
            res.fwd = 1'b1;
        end else if (sum[ACC_W-1]) begin
            nxt      = sum + modv;
            res.back = 1'b1;
        end else begin
            nxt = sum;
        end
        res.acc = nxt[ACC_W-2:0];
        return res;
    endfunction

endpackage

// File: rtl/samp_clk_regs.sv
module samp_clk_regs
    import samp_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              gen_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [RATE_W-1:0] rate_q,
    output logic              shift_clr,
    output logic              shift_load,
    output shift_t            shift_wdata
);

    logic rate_hold;

    assign rate_hold   = rst | pwr_dn;
    assign shift_clr   = rst | pwr_dn | ~gen_en;
    assign shift_load  = wr_en & wr_sel & ~shift_clr;
    assign shift_wdata = '{dir: wr_data[MAG_W], mag: wr_data[MAG_W-1:0]};

    always_ff @(posedge clk) begin
        if (rate_hold) begin
            rate_q <= RATE_DEF;
        end else if (wr_en && !wr_sel) begin
            rate_q <= wr_data[RATE_W-1:0];
        end
    end

    // R3: power-down forces the rate word back to its default
    a_r3_rate_default: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (rate_q == RATE_DEF));

    // R5: no shift load can get through while the register is locked
    a_r5_no_load_when_locked: assert property (@(posedge clk) disable iff (rst)
        shift_clr |-> !shift_load);

endmodule

// File: rtl/samp_clk_shift.sv
module samp_clk_shift
    import samp_clk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   load,
    input  shift_t wdata,
    output shift_t state_q,
    output adj_e   adj
);

    logic [DIV_W-1:0] div_q;
    logic             tick;

    assign tick = (div_q == DIV_W'(TICK_DIV - 1)) && (state_q.mag != '0) && !clr && !load;

    always_comb begin
        if (!tick)              adj = ADJ_NONE;
        else if (state_q.dir)   adj = ADJ_BACK;
        else                    adj = ADJ_FWD;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= '0;
            div_q   <= '0;
        end else if (load) begin
            state_q <= wdata;
            div_q   <= '0;
        end else begin
            div_q <= (div_q == DIV_W'(TICK_DIV - 1)) ? '0 : div_q + 1'b1;
            if (tick) begin
                state_q.mag <= state_q.mag - 1'b1;
            end
        end
    end

    // R5: a locked register is empty on the following cycle
    a_r5_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state_q == '0));

    // R6: without a load, the magnitude only ever drops by one
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load) |=> ((state_q.mag == $past(state_q.mag)) ||
                             (state_q.mag == $past(state_q.mag) - 1'b1)));

    // R6: no decrement except at the end of an eight-cycle prescaler run
    a_r6_paced: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && div_q != DIV_W'(TICK_DIV - 1)) |=> $stable(state_q));

endmodule

// File: rtl/samp_clk_acc.sv
module samp_clk_acc
    import samp_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    input  adj_e              adj,
    output logic              strobe
);

    localparam logic [ACC_W-2:0] MOD_U = (ACC_W-1)'(MCLK_HZ);

    logic [ACC_W-2:0] acc_q;
    logic             debt_q;
    acc_step_t        nxt;

    always_comb nxt = acc_advance(acc_q, rate, adj);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            debt_q <= 1'b0;
            strobe <= 1'b0;
        end else begin
            acc_q  <= nxt.acc;
            strobe <= nxt.fwd & ~debt_q;
            if (nxt.back)     debt_q <= 1'b1;
            else if (nxt.fwd) debt_q <= 1'b0;
        end
    end

    // R10: the phase stays inside one modulus
    a_r10_acc_in_range: assert property (@(posedge clk) disable iff (rst)
        acc_q < MOD_U);

    // R1: strobes never come back to back
    a_r1_no_double: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R10: a backward crossing withholds the strobe of the next wrap
    a_r10_debt_silent: assert property (@(posedge clk) disable iff (rst)
        debt_q |=> !strobe);

endmodule

// File: rtl/samp_clk_gen.sv
module samp_clk_gen
    import samp_clk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_dn,
    input  logic        gen_en,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        rd_sel,
    output logic [15:0] rd_data,
    output logic        strobe
);

    logic [RATE_W-1:0] rate_q;
    logic              shift_clr;
    logic              shift_load;
    shift_t            shift_wdata;
    shift_t            shift_q;
    adj_e              adj;

    samp_clk_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .pwr_dn      (pwr_dn),
        .gen_en      (gen_en),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rate_q      (rate_q),
        .shift_clr   (shift_clr),
        .shift_load  (shift_load),
        .shift_wdata (shift_wdata)
    );

    samp_clk_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr     (shift_clr),
        .load    (shift_load),
        .wdata   (shift_wdata),
        .state_q (shift_q),
        .adj     (adj)
    );

    samp_clk_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .rate   (rate_q),
        .adj    (adj),
        .strobe (strobe)
    );

    always_comb begin
        if (rd_sel) rd_data = {{RSV_W{1'b0}}, shift_q.dir, shift_q.mag};
        else        rd_data = {{(REG_W-RATE_W){1'b0}}, rate_q};
    end

endmodule

// File: tb/samp_clk_gen_bench.sv
module samp_clk_gen_bench;

    localparam longint MCLK = 24_576_000;
    localparam int     WIN  = 12288;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn = 1'b0;
    logic        gen_en = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        strobe;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    samp_clk_gen u_samp_clk_gen (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .gen_en(gen_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .strobe(strobe)
    );

    task automatic chk(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic chk_rng(input string req, input longint got, input longint lo, input longint hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, got, lo, hi);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] d);
        wr_sel  = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [15:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wait_strobe(output longint at);
        do @(negedge clk); while (!strobe);
        at = cyc;
    endtask

    task automatic count_window(input longint rate, input string req);
        int n;
        int dbl;
        logic prev;
        n = 0; dbl = 0; prev = 1'b0;
        repeat (WIN) begin
            @(negedge clk);
            if (strobe) n++;
            if (strobe && prev) dbl++;
            prev = strobe;
        end
        chk_rng(req, n, (WIN * rate) / MCLK, (WIN * rate) / MCLK + 1);
        chk({req, " single-cycle"}, dbl, 0);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        report();
    end

    initial begin
        logic [15:0] v;
        longint t0, t1, t2;

        repeat (3) @(negedge clk);
        chk("R1 reset strobe", strobe, 0);
        read_reg(0, v); chk("R3 reset rate", v, 16'hBB80);
        read_reg(1, v); chk("R5 reset shift", v, 0);
        rst = 1'b0;

        // R1 default 48 kHz and other rates, R2 range limits
        count_window(48000, "R1 rate 48000");
        reg_write(0, 16'd44100); repeat (4) @(negedge clk);
        count_window(44100, "R1 rate 44100");
        reg_write(0, 16'd12000); repeat (4) @(negedge clk);
        count_window(12000, "R1 rate 12000");
        reg_write(0, 16'h0FA0); repeat (4) @(negedge clk);
        count_window(4000, "R2 rate 4000");
        reg_write(0, 16'hD2F0); repeat (4) @(negedge clk);
        count_window(54000, "R2 rate 54000");
        read_reg(0, v); chk("R3 rate readback", v, 16'hD2F0);

        // R4 field layout, reserved bits dropped
        reg_write(1, 16'hFE05);
        read_reg(1, v); chk("R4 reserved ignored", v, 16'h0005);
        repeat (40) @(negedge clk);
        read_reg(1, v); chk("R4 run down", v, 16'h0000);

        // R6 step pacing
        reg_write(1, 16'h0014);
        read_reg(1, v); chk("R6 loaded", v, 20);
        repeat (8) @(negedge clk);
        read_reg(1, v); chk("R6 after 8", v, 19);
        repeat (8 * 20 - 9) @(negedge clk);
        read_reg(1, v); chk("R6 at 8N-1", v, 1);
        @(negedge clk);
        read_reg(1, v); chk("R6 at 8N", v, 0);

        // R7 overwrite while pending
        reg_write(1, 16'h0164);
        repeat (40) @(negedge clk);
        read_reg(1, v); chk("R7 partial", v, 16'h015F);
        reg_write(1, 16'h0103);
        read_reg(1, v); chk("R7 replaced", v, 16'h0103);
        repeat (23) @(negedge clk);
        read_reg(1, v); chk("R7 at 8N-1", v, 16'h0101);
        @(negedge clk);
        read_reg(1, v); chk("R7 at 8N", v, 16'h0100);

        // R5 locking by gen_en and power-down, R3 power-down
        gen_en = 1'b0;
        @(negedge clk);
        reg_write(1, 16'h0107);
        read_reg(1, v); chk("R5 gen_en low blocks write", v, 0);
        gen_en = 1'b1;
        @(negedge clk);
        reg_write(1, 16'h0033);
        read_reg(1, v); chk("R5 write when enabled", v, 16'h0033);
        pwr_dn = 1'b1;
        @(negedge clk);
        read_reg(1, v); chk("R5 power-down clears shift", v, 0);
        read_reg(0, v); chk("R3 power-down restores rate", v, 16'hBB80);
        reg_write(0, 16'h1234);
        read_reg(0, v); chk("R3 power-down blocks write", v, 16'hBB80);
        pwr_dn = 1'b0;
        @(negedge clk);
        read_reg(0, v); chk("R3 after power-down", v, 16'hBB80);

        // R8 advance / R9 retard at 8192 Hz (3000-cycle period)
        reg_write(0, 16'h2000);
        wait_strobe(t0); wait_strobe(t0); wait_strobe(t1);
        chk("R8 base period", t1 - t0, 3000);
        reg_write(1, 16'h000A);
        wait_strobe(t2); chk("R8 advance 10", t2 - t1, 2990);
        wait_strobe(t0); chk("R8 period restored", t0 - t2, 3000);
        reg_write(1, 16'h00C8);
        wait_strobe(t1); chk("R8 advance 200", t1 - t0, 2800);
        wait_strobe(t2);
        reg_write(1, 16'h0125);
        wait_strobe(t0); chk("R9 retard 37", t0 - t2, 3037);

        // R10 retard step landing one cycle after a wrap, rate 4096 Hz
        reg_write(0, 16'h1000);
        wait_strobe(t0); wait_strobe(t0);
        repeat (5992) @(negedge clk);
        reg_write(1, 16'h0101);
        wait_strobe(t1); chk("R10 period before step", t1 - t0, 6000);
        wait_strobe(t2); chk("R10 no repeated edge", t2 - t1, 6002);

        report();
    end

endmodule